// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port

This block is an 8-bit synchronous serial port with a small register interface for a host processor. Software writes a configuration byte to choose the clock source, the clock polarity, the transfer mode and the input pin. It loads a byte into the shift register and sets the start bit. The port then moves eight bits out on the data-out pin, in from the data-in pin, or both at once, most significant bit first. At the end it raises a one-cycle interrupt pulse and sets a completion flag. The received byte can then be read from the data register.

The serial clock can be the system clock divided by 4, the system clock divided by 16, or a toggle on each timer-overflow pulse. In these three cases the port is the master and drives the clock pin. The clock can also come in on the clock pin from an external master. That input is synchronised into the system clock domain and the port acts as a slave. The data input can be taken from the data-out pin instead of the data-in pin, which allows half-duplex operation on a single wire. The output-enable signals show which pins the port has taken over from general-purpose use.

Top module: `sio_serial_port`

## Requirements
- R1: After a synchronous reset the control register reads 0x00, the data register reads 0x00, and `sclk_out`, `sclk_oe`, `sdo_oe` and `irq` are all 0.
- R2: `bus_sel`=0 selects the control register and `bus_sel`=1 selects the data register, and reads are combinational on `bus_rdata`. The control register layout is: bit 7 input select, bit 6 polarity, bits 5:4 clock source, bits 3:2 mode, bit 1 completion flag (read-only), bit 0 start. A data-register write while idle loads the shift register.
- R3: Clock source 00 toggles the serial clock every 4 system cycles and source 01 every 16, with the first toggle 4 (or 16) cycles after the edge that accepts the start write. Source 10 toggles once per `tmr_ovf` pulse. Source 11 takes edges from `sclk_in` through a two-flop synchroniser. `sclk_oe` is 1 exactly when the mode is not 00 and the source is not 11.
- R4: The edge that leaves the idle level samples the input bit, and the edge that returns to it shifts the register left, with the sample entering bit 0. `sdo_out` always shows bit 7.
- R5: The idle level of `sclk_out` equals the polarity bit. A transfer has exactly eight serial clock periods, and then the clock rests at the idle level.
- R6: A control write with bit 0 set and a mode other than 00 starts a transfer. The start bit then reads 1 until the first leaving edge and 0 after it. The completion flag reads 0 from the start and 1 from the end of the transfer until the next start.
- R7: `irq` is high for exactly one system cycle, in the same cycle in which the completion flag first reads 1.
- R8: Mode bit 2 (transmit) drives `sdo_oe`. Mode bit 3 (receive) enables reception. In mode 01 the sampled input is forced to 0, so the register holds 0x00 after a transfer.
- R9: With input select = 1 the port samples `sdo_in` (the pad value of the data-out pin) instead of `sdi_in`.
- R10: Writes to either register while a transfer is running are ignored.
- R11: A start write with mode 00 starts nothing: the completion flag and the shift register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 = control register, 1 = data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| tmr_ovf | input | 1 | Timer overflow pulse, used as a clock source |
| sclk_in | input | 1 | Serial clock pad input (slave mode) |
| sclk_out | output | 1 | Serial clock driven in master modes |
| sclk_oe | output | 1 | Port drives the clock pin |
| sdo_in | input | 1 | Pad value of the data-out pin |
| sdo_out | output | 1 | Serial data out |
| sdo_oe | output | 1 | Port drives the data-out pin |
| sdi_in | input | 1 | Serial data in |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Full-duplex transfers with the fast divider are run at both polarities. Comparing the clock pin cycle by cycle against the model separates the leaving edge from the returning edge and the sample from the shift. A slow-divider receive-only transfer and a timer-paced transmit-only transfer with irregular overflow pulses show that the clock advances only on its chosen source, and that disabled reception clears the incoming bits. A receive with input select set, driven with opposite data on the two input pins, shows which pin is sampled. An externally clocked transfer tests the synchronised slave path. A mid-transfer write to each register, and a start in port mode, confirm that those writes are ignored.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int BYTE_W = 8;
    localparam int FAST_DIV = 4;
    localparam int SLOW_DIV = 16;
    localparam int B_START = 0;
    localparam int B_DONE = 1;

    typedef enum logic [1:0] {
        CK_FAST = 2'b00,
        CK_SLOW = 2'b01,
        CK_TMR  = 2'b10,
        CK_EXT  = 2'b11
    } ck_src_e;

    typedef enum logic [1:0] {
        MD_PORT = 2'b00,
        MD_TX   = 2'b01,
        MD_RX   = 2'b10,
        MD_TRX  = 2'b11
    } md_e;

    // writable configuration, packed to match control bits 7..2
    typedef struct packed {
        logic    in_alt;
        logic    pol;
        ck_src_e src;
        md_e     mode;
    } cfg_t;

    function automatic logic md_tx(md_e m);
        return m[0];
    endfunction

    function automatic logic md_rx(md_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/sio_edge_gen.sv
module sio_edge_gen
    import sio_pkg::*;
#(
    parameter int FDIV = FAST_DIV,
    parameter int SDIV = SLOW_DIV
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  ck_src_e src,
    input  logic    pol,
    input  logic    idle_lvl,
    input  logic    tmr_ovf,
    input  logic    sclk_in,
    output logic    lead,
    output logic    trail,
    output logic    sclk_q
);

    localparam int PW = $clog2(SDIV);
    localparam int FW = $clog2(FDIV);

    logic [PW-1:0] presc;
    logic [2:0]    sync;
    logic          tick;
    logic          int_mode;
    logic          ext_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            presc <= '0;
            sync  <= '0;
        end else begin
            sync <= {sync[1:0], sclk_in};
            if (!busy) presc <= '0;
            else       presc <= presc + 1'b1;
        end
    end

    always_comb begin
        tick = 1'b0;
        case (src)
            CK_FAST: tick = (presc[FW-1:0] == {FW{1'b1}});
            CK_SLOW: tick = (presc == {PW{1'b1}});
            CK_TMR:  tick = tmr_ovf;
            default: tick = 1'b0;
        endcase
    end

    assign int_mode = (src != CK_EXT);
    assign ext_edge = (sync[1] != sync[2]);

    assign lead  = busy && (int_mode ? (tick && (sclk_q == pol))
                                     : (ext_edge && (sync[1] != pol)));
    assign trail = busy && (int_mode ? (tick && (sclk_q != pol))
                                     : (ext_edge && (sync[1] == pol)));

    always_ff @(posedge clk) begin
        if (rst)                  sclk_q <= 1'b0;
        else if (!busy)           sclk_q <= idle_lvl;
        else if (int_mode && tick) sclk_q <= ~sclk_q;
    end

    // R5: clock rests at the idle level whenever no transfer runs
    a_r5_idle_level: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk_q == pol));

endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         start,
    input  logic         lead,
    input  logic         trail,
    input  logic         rx_bit,
    output logic [W-1:0] sreg,
    output logic         last
);

    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic          samp;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            cnt  <= '0;
            samp <= 1'b0;
        end else begin
            if (load)       sreg <= load_val;
            else if (trail) sreg <= {sreg[W-2:0], samp};
            if (start)      cnt <= '0;
            else if (trail) cnt <= cnt + 1'b1;
            if (lead)       samp <= rx_bit;
        end
    end

    assign last = trail && (cnt == {CW{1'b1}});

    // R4: register only moves on a returning edge or an idle load
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !trail) |=> $stable(sreg));

    // R5: each returning edge advances the bit count by one
    a_r5_count: assert property (@(posedge clk) disable iff (rst)
        trail |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/sio_serial_port.sv
module sio_serial_port
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       tmr_ovf,
    input  logic       sclk_in,
    output logic       sclk_out,
    output logic       sclk_oe,
    input  logic       sdo_in,
    output logic       sdo_out,
    output logic       sdo_oe,
    input  logic       sdi_in,
    output logic       irq
);

    cfg_t              cfg;
    cfg_t              cfg_w;
    logic              busy;
    logic              done;
    logic              startp;
    logic              irq_q;
    logic              wr_ctl;
    logic              wr_dat;
    logic              go;
    logic              idle_lvl;
    logic              lead;
    logic              trail;
    logic              last;
    logic              rx_bit;
    logic              sclk_q;
    logic [BYTE_W-1:0] sreg;
    logic              unused_wbit;

    assign cfg_w       = cfg_t'(bus_wdata[7:2]);
    assign unused_wbit = bus_wdata[B_DONE];
    assign wr_ctl      = bus_wr && !bus_sel && !busy;
    assign wr_dat      = bus_wr && bus_sel && !busy;
    assign go          = wr_ctl && bus_wdata[B_START] && (cfg_w.mode != MD_PORT);
    assign idle_lvl    = wr_ctl ? cfg_w.pol : cfg.pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            startp <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_ctl) cfg <= cfg_w;
            if (go) begin
                busy   <= 1'b1;
                startp <= 1'b1;
                done   <= 1'b0;
            end
            if (lead) startp <= 1'b0;
            if (last) begin
                busy  <= 1'b0;
                done  <= 1'b1;
                irq_q <= 1'b1;
            end
        end
    end

    assign rx_bit = md_rx(cfg.mode) ? (cfg.in_alt ? sdo_in : sdi_in) : 1'b0;

    sio_edge_gen #(
        .FDIV(FAST_DIV),
        .SDIV(SLOW_DIV)
    ) u_edge (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .src     (cfg.src),
        .pol     (cfg.pol),
        .idle_lvl(idle_lvl),
        .tmr_ovf (tmr_ovf),
        .sclk_in (sclk_in),
        .lead    (lead),
        .trail   (trail),
        .sclk_q  (sclk_q)
    );

    sio_shift_core #(
        .W(BYTE_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (wr_dat),
        .load_val(bus_wdata),
        .start   (go),
        .lead    (lead),
        .trail   (trail),
        .rx_bit  (rx_bit),
        .sreg    (sreg),
        .last    (last)
    );

    assign bus_rdata = bus_sel ? sreg : {cfg, done, startp};
    assign sclk_out  = sclk_q;
    assign sclk_oe   = (cfg.mode != MD_PORT) && (cfg.src != CK_EXT);
    assign sdo_out   = sreg[BYTE_W-1];
    assign sdo_oe    = md_tx(cfg.mode);
    assign irq       = irq_q;

    // R7: completion pulse lasts one cycle
    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R7: flag rises together with the pulse
    a_r7_done_with_irq: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> irq);

    // R10: configuration frozen while busy
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_wr) |=> $stable(cfg));

    // R11: a start in port mode launches nothing
    a_r11_port_start: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_sel && !busy && bus_wdata[B_START] && (bus_wdata[3:2] == 2'b00))
        |=> !busy);

    // R6: start bit drops only while the transfer keeps running
    a_r6_start_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(startp) |-> (busy || done));

endmodule

// File: tb/sio_serial_port_tb.sv
module sio_serial_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tmr_ovf = 1'b0;
    logic       sclk_in = 1'b0;
    logic       sclk_out;
    logic       sclk_oe;
    logic       sdo_in = 1'b0;
    logic       sdo_out;
    logic       sdo_oe;
    logic       sdi_in = 1'b0;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sio_serial_port u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .sdo_in(sdo_in), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
        .sdi_in(sdi_in), .irq(irq)
    );

    always @(negedge clk) if (irq === 1'b1) irq_cnt++;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic drive_rx(input logic alt, input logic b);
        if (alt) begin sdo_in = b; sdi_in = ~b; end
        else     begin sdi_in = b; sdo_in = ~b; end
    endtask

    // internally clocked transfer, compared against a tick-counting model every cycle
    task automatic run_int(input logic alt, input logic pl, input logic [1:0] sr,
                           input logic [1:0] md, input logic [7:0] tx,
                           input logic [7:0] rx, input bit inj);
        logic [7:0]  rxe;
        logic [15:0] cat;
        int t;
        int k;
        int per;
        bit tk;
        rxe = md[1] ? rx : 8'h00;
        cat = {tx, rxe};
        per = (sr == 2'b00) ? 4 : 16;
        t = 0;
        k = 0;
        wr(1'b1, tx);
        tmr_ovf = 1'b0;
        drive_rx(alt, rx[7]);
        wr(1'b0, {alt, pl, sr, md, 2'b01});
        chk("R6 start bit set, flag clear", {14'd0, bus_rdata[1:0]}, 16'h0001);
        chk("R8 data-out enable", {15'd0, sdo_oe}, {15'd0, md[0]});
        chk("R3 clock enable", {15'd0, sclk_oe}, 16'h0001);
        while (t < 16) begin
            k++;
            bus_wr = 1'b0; bus_sel = 1'b0;
            if (inj && k == 20) begin bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 8'h5A; end
            if (inj && k == 30) begin bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = 8'hFF; end
            tmr_ovf = (sr == 2'b10) && (k % 3 == 0);
            drive_rx(alt, rx[7 - t / 2]);
            @(negedge clk);
            tk = (sr == 2'b10) ? tmr_ovf : (k % per == 0);
            if (tk) t++;
            chk("R5 R3 clock level", {15'd0, sclk_out}, {15'd0, pl ^ t[0]});
            chk("R4 data out bit", {15'd0, sdo_out}, {15'd0, cat[15 - t / 2]});
            chk("R7 irq", {15'd0, irq}, {15'd0, (tk && t == 16)});
            if (!bus_sel)
                chk("R6 status bits", {14'd0, bus_rdata[1:0]}, {14'd0, (t == 16), (t == 0)});
        end
        bus_wr = 1'b0; tmr_ovf = 1'b0;
        bus_sel = 1'b1; #1;
        chk("R4 R8 R9 R10 received byte", {8'd0, bus_rdata}, {8'd0, rxe});
        bus_sel = 1'b0; #1;
        chk("R10 control unchanged", {8'd0, bus_rdata}, {8'd0, alt, pl, sr, md, 2'b10});
        @(negedge clk);
        chk("R7 irq drops", {15'd0, irq}, 16'h0000);
        chk("R5 clock rests", {15'd0, sclk_out}, {15'd0, pl});
    endtask

    task automatic run_ext(input logic pl, input logic [7:0] tx, input logic [7:0] rx);
        int c0;
        sclk_in = pl;
        wr(1'b0, {1'b0, pl, 2'b11, 2'b11, 2'b00});
        repeat (4) @(negedge clk);
        wr(1'b1, tx);
        c0 = irq_cnt;
        wr(1'b0, {1'b0, pl, 2'b11, 2'b11, 2'b01});
        chk("R3 slave leaves clock pin", {15'd0, sclk_oe}, 16'h0000);
        for (int i = 0; i < 8; i++) begin
            sdi_in = rx[7 - i];
            chk("R4 slave data out", {15'd0, sdo_out}, {15'd0, tx[7 - i]});
            sclk_in = ~pl;
            repeat (6) @(negedge clk);
            sclk_in = pl;
            repeat (6) @(negedge clk);
        end
        chk("R3 slave pulse count", irq_cnt - c0, 16'd1);
        bus_sel = 1'b1; #1;
        chk("R3 slave received byte", {8'd0, bus_rdata}, {8'd0, rx});
        bus_sel = 1'b0; #1;
        chk("R6 slave flag", {15'd0, bus_rdata[1]}, 16'h0001);
        chk("R5 slave clock idle", {15'd0, sclk_out}, {15'd0, pl});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 control reset", {8'd0, bus_rdata}, 16'h0000);
        chk("R1 clock out", {15'd0, sclk_out}, 16'h0000);
        chk("R1 clock enable", {15'd0, sclk_oe}, 16'h0000);
        chk("R1 data enable", {15'd0, sdo_oe}, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        bus_sel = 1'b1; #1;
        chk("R1 R2 data reset", {8'd0, bus_rdata}, 16'h0000);
        bus_sel = 1'b0;
        @(negedge clk);

        run_int(1'b0, 1'b0, 2'b00, 2'b11, 8'hA5, 8'h3C, 1'b0);
        run_int(1'b0, 1'b1, 2'b00, 2'b11, 8'h96, 8'hC3, 1'b1);
        run_int(1'b0, 1'b0, 2'b01, 2'b10, 8'h0F, 8'h81, 1'b0);
        run_int(1'b0, 1'b1, 2'b10, 2'b01, 8'h5B, 8'hE7, 1'b0);
        run_int(1'b1, 1'b0, 2'b00, 2'b10, 8'h11, 8'h6E, 1'b0);
        run_ext(1'b0, 8'hC9, 8'h72);
        run_ext(1'b1, 8'h3A, 8'hB4);

        // R11: start in port mode does nothing
        begin
            int c0;
            c0 = irq_cnt;
            wr(1'b0, 8'h01);
            chk("R11 R2 control after port start", {8'd0, bus_rdata}, 16'h0002);
            repeat (20) @(negedge clk);
            chk("R11 still idle", {8'd0, bus_rdata}, 16'h0002);
            chk("R11 no pulse", irq_cnt - c0, 16'd0);
            chk("R11 pins released", {14'd0, sclk_oe, sdo_oe}, 16'h0000);
            bus_sel = 1'b1; #1;
            chk("R11 data kept", {8'd0, bus_rdata}, 16'h00B4);
            bus_sel = 1'b0;
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule